// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an asynchronous 128K x 8 static RAM. The host issues single-beat reads and writes over a valid/ready request port. The controller turns each one into a sequence of registered strobes on the memory pins, and every phase of that sequence is held for a whole number of clock cycles. The RAM is selected only while its active-low select is low and its active-high select is high. It reads when its write strobe is high and its output enable is low, and it writes whenever its write strobe is low. Data travels on a shared bus, which the controller models as a separate output value, output-enable and input value.

Access timings are parameters given in nanoseconds, together with the clock period. Each one is rounded up to whole cycles, with a floor of one cycle. A per-request mode input picks which pin ends a write. The first option is a write-enable pulse inside a chip-select window. The second and third hold the write enable low and strobe one of the two selects. After reset, the controller waits one read cycle time before it accepts the first request.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and after it, until the first request: mem_cs1_n=1, mem_cs2=0, mem_we_n=1, mem_oe_n=1, mem_dout_oe=0 and req_ready=0. req_ready rises exactly ceil(T_RC_NS/CLK_NS) clock edges after reset is released.
- R2: A request accepted (req_valid=1, req_write=0) at edge A holds mem_cs1_n=0, mem_cs2=1, mem_oe_n=0 and mem_we_n=1 for RDC = ceil(max(T_AA_NS,T_RC_NS)/CLK_NS) cycles. At edge A+RDC it samples mem_din into rd_data and raises rd_valid for exactly one cycle.
- R3: req_mode 2'b00 (and 2'b11) gives a write ended by mem_we_n. Both selects are active first, mem_we_n then goes low for the strobe and rises while the selects remain active.
- R4: req_mode 2'b01 gives a write ended by mem_cs1_n. mem_we_n and mem_cs2 are active first, mem_cs1_n then pulses low and rises while mem_we_n is still low.
- R5: req_mode 2'b10 gives a write ended by mem_cs2. mem_we_n and mem_cs1_n are low first, mem_cs2 then pulses high and falls while mem_we_n is still low.
- R6: During a write, mem_addr stays stable and mem_dout_oe is on for the whole strobe plus one cycle after the strobe ends, with mem_dout unchanged. When req_ready returns, the data drivers are off.
- R7: mem_dout_oe is never 1 while mem_oe_n is 0, and mem_dout_oe rises only after mem_oe_n has been 1 for at least one full cycle. mem_oe_n is 1 whenever mem_we_n is 0.
- R8: A write accepted at edge A returns req_ready at edge A+1+SC+RC. Here SC = max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS)) and RC = max(1, ceil(T_WC_NS/CLK_NS)-SC-1).
- R9: req_mode is sampled only when a write is accepted. A change during the write does not alter which pin ends it.
- R10: The write strobe lasts at least ceil(T_WP_NS/CLK_NS) cycles, and write data is stable on the bus for at least ceil(T_DW_NS/CLK_NS) cycles before the strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Write style: 00/11 write-enable, 01 low-select, 10 high-select |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dout | output | DATA_W | Data driven toward memory |
| mem_dout_oe | output | 1 | Enables the controller's data drivers |
| mem_din | input | DATA_W | Data returned by memory |

## Verification
A read accepted at edge A yields rd_valid at edge A+RDC, which is three cycles with the bench's 8 ns timing base. The driver pushes the expected byte and that due cycle into a queue, and the monitor compares both when rd_valid appears. A write returns req_ready 1+SC+RC edges after acceptance, which is four cycles here, and the driver checks that count at the negative edge where ready is first seen. A behavioural RAM samples the pins at each negative edge. It returns unknown data until the access time in cycles has elapsed, counts strobe and data-stable cycles, detects which pin ended each write, and flags bus contention.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [1:0] {
      WSTY_WE   = 2'b00,
      WSTY_CS1  = 2'b01,
      WSTY_CS2  = 2'b10,
      WSTY_ALT  = 2'b11
   } wr_style_t;

   typedef enum logic [2:0] {
      PH_WAKE,
      PH_IDLE,
      PH_READ,
      PH_ARM,
      PH_STRB,
      PH_REC
   } phase_t;

   typedef struct packed {
      logic cs1_n;
      logic cs2;
      logic we_n;
      logic oe_n;
   } pins_t;

   localparam pins_t PINS_IDLE  = '{cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b1, oe_n: 1'b1};
   localparam pins_t PINS_READ  = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b0};
   localparam pins_t PINS_WRITE = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b0, oe_n: 1'b1};

   // nanoseconds to whole cycles, rounded up, never below one
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // pin levels on either side of the strobe: only the ending pin differs
   function automatic pins_t armed_pins(input wr_style_t s);
      pins_t p;
      case (s)
         WSTY_CS1: p = '{cs1_n: 1'b1, cs2: 1'b1, we_n: 1'b0, oe_n: 1'b1};
         WSTY_CS2: p = '{cs1_n: 1'b0, cs2: 1'b0, we_n: 1'b0, oe_n: 1'b1};
         default:  p = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b1};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
   parameter int CW      = 4,
   parameter int RST_VAL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   assign expired = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CW'(RST_VAL);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (!expired) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/sram_strobe_map.sv
module sram_strobe_map
   import sram_ctrl_pkg::*;
(
   input  phase_t    phase,
   input  wr_style_t style,
   output pins_t     pins,
   output logic      drive
);

   always_comb begin
      case (phase)
         PH_READ:        pins = PINS_READ;
         PH_ARM, PH_REC: pins = armed_pins(style);
         PH_STRB:        pins = PINS_WRITE;
         default:        pins = PINS_IDLE;
      endcase
      drive = (phase == PH_STRB) || (phase == PH_REC);
   end

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 8,
   parameter int RD_CYC   = 1,
   parameter int STRB_CYC = 1,
   parameter int REC_CYC  = 1,
   parameter int WAKE_CYC = 1,
   parameter int CW       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_mode,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_din,
   output logic              req_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output phase_t            phase_nxt,
   output wr_style_t         style_nxt,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q
);

   phase_t        phase_q;
   wr_style_t     style_q;
   logic          accept;
   logic          load;
   logic [CW-1:0] load_val;
   logic          expired;

   sram_cycle_timer #(
      .CW      (CW),
      .RST_VAL (WAKE_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   always_comb begin
      phase_nxt = phase_q;
      accept    = 1'b0;
      load      = 1'b0;
      load_val  = '0;
      case (phase_q)
         PH_WAKE: if (expired) phase_nxt = PH_IDLE;
         PH_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               if (req_write) begin
                  phase_nxt = PH_ARM;
               end else begin
                  phase_nxt = PH_READ;
                  load      = 1'b1;
                  load_val  = CW'(RD_CYC - 1);
               end
            end
         end
         PH_READ: if (expired) phase_nxt = PH_IDLE;
         PH_ARM: begin
            phase_nxt = PH_STRB;
            load      = 1'b1;
            load_val  = CW'(STRB_CYC - 1);
         end
         PH_STRB: begin
            if (expired) begin
               phase_nxt = PH_REC;
               load      = 1'b1;
               load_val  = CW'(REC_CYC - 1);
            end
         end
         PH_REC: if (expired) phase_nxt = PH_IDLE;
         default: phase_nxt = PH_IDLE;
      endcase
      style_nxt = accept ? wr_style_t'(req_mode) : style_q;
   end

   assign req_ready = (phase_q == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_WAKE;
         style_q  <= WSTY_WE;
         addr_q   <= '0;
         wdata_q  <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         phase_q  <= phase_nxt;
         style_q  <= style_nxt;
         if (accept) begin
            addr_q <= req_addr;
            if (req_write) wdata_q <= req_wdata;
         end
         rd_valid <= (phase_q == PH_READ) && expired;
         if ((phase_q == PH_READ) && expired) rd_data <= mem_din;
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 8,
   parameter int CLK_NS   = 10,
   parameter int T_AA_NS  = 20,
   parameter int T_RC_NS  = 20,
   parameter int T_WP_NS  = 15,
   parameter int T_DW_NS  = 10,
   parameter int T_WC_NS  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [1:0]        req_mode,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_oe,
   input  logic [DATA_W-1:0] mem_din
);

   localparam int RD_CYC   = ns_to_cyc(imax(T_AA_NS, T_RC_NS), CLK_NS);
   localparam int WP_CYC   = ns_to_cyc(T_WP_NS, CLK_NS);
   localparam int DW_CYC   = ns_to_cyc(T_DW_NS, CLK_NS);
   localparam int WC_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
   localparam int STRB_CYC = imax(WP_CYC, DW_CYC);
   localparam int REC_CYC  = imax(1, WC_CYC - STRB_CYC - 1);
   localparam int WAKE_CYC = ns_to_cyc(T_RC_NS, CLK_NS);
   localparam int MAX_CYC  = imax(imax(RD_CYC, STRB_CYC), imax(REC_CYC, WAKE_CYC));
   localparam int CW       = imax(1, $clog2(MAX_CYC + 1));

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_async_ctrl: address and data widths must be positive");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("sram_async_ctrl: clock period must be at least 1 ns");
      end
      if (T_AA_NS < 0 || T_RC_NS < 0 || T_WP_NS < 0 || T_DW_NS < 0 || T_WC_NS < 0) begin : g_bad_time
         $error("sram_async_ctrl: timing values must not be negative");
      end
   endgenerate

   phase_t    phase_nxt;
   wr_style_t style_nxt;
   pins_t     pins_nxt;
   pins_t     pins_q;
   logic      drv_nxt;
   logic      drv_q;

   sram_ctrl_seq #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .RD_CYC   (RD_CYC),
      .STRB_CYC (STRB_CYC),
      .REC_CYC  (REC_CYC),
      .WAKE_CYC (WAKE_CYC),
      .CW       (CW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_mode  (req_mode),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_din   (mem_din),
      .req_ready (req_ready),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .phase_nxt (phase_nxt),
      .style_nxt (style_nxt),
      .addr_q    (mem_addr),
      .wdata_q   (mem_dout)
   );

   sram_strobe_map u_map (
      .phase (phase_nxt),
      .style (style_nxt),
      .pins  (pins_nxt),
      .drive (drv_nxt)
   );

   // every memory control pin comes straight from a flop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins_q <= PINS_IDLE;
         drv_q  <= 1'b0;
      end else begin
         pins_q <= pins_nxt;
         drv_q  <= drv_nxt;
      end
   end

   assign mem_cs1_n   = pins_q.cs1_n;
   assign mem_cs2     = pins_q.cs2;
   assign mem_we_n    = pins_q.we_n;
   assign mem_oe_n    = pins_q.oe_n;
   assign mem_dout_oe = drv_q;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs1_n,
   input logic              mem_cs2,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_dout_oe
);

   logic wr_act;
   assign wr_act = !mem_cs1_n && mem_cs2 && !mem_we_n;

   // R1
   idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dout_oe));

   // R2
   rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_act && $past(wr_act)) |-> $stable(mem_addr));

   // R7
   drive_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dout_oe |-> mem_oe_n);

   // R7
   turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dout_oe) |-> $past(mem_oe_n));

   // R7
   we_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .rd_valid    (rd_valid),
   .mem_addr    (mem_addr),
   .mem_cs1_n   (mem_cs1_n),
   .mem_cs2     (mem_cs2),
   .mem_we_n    (mem_we_n),
   .mem_oe_n    (mem_oe_n),
   .mem_dout_oe (mem_dout_oe)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;

   // timing base handed to the controller; all windows below count cycles
   localparam int CFG_CLK = 8;
   localparam int RD_NEED = (20 + CFG_CLK - 1) / CFG_CLK;
   localparam int WP_NEED = (15 + CFG_CLK - 1) / CFG_CLK;
   localparam int DW_NEED = (10 + CFG_CLK - 1) / CFG_CLK;
   localparam int WC_NEED = (20 + CFG_CLK - 1) / CFG_CLK;
   localparam int SC_EXP  = (WP_NEED > DW_NEED) ? WP_NEED : DW_NEED;
   localparam int RC_EXP  = (WC_NEED - SC_EXP - 1 < 1) ? 1 : WC_NEED - SC_EXP - 1;
   localparam int WR_BUSY = 1 + SC_EXP + RC_EXP;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_mode = 2'b00;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic [16:0] mem_addr;
   logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dout_oe;
   logic [7:0]  mem_dout;
   logic [7:0]  mem_din;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sram_async_ctrl #(.CLK_NS(CFG_CLK)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_mode(req_mode), .req_addr(req_addr),
      .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout),
      .mem_dout_oe(mem_dout_oe), .mem_din(mem_din)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] init_val(input logic [16:0] a);
      return a[7:0] ^ 8'h5A;
   endfunction

   // ---------------- behavioural RAM ----------------
   logic [7:0]  dev_mem [int];
   logic [7:0]  din_drv = 8'hxx;
   logic [1:0]  style_q [$];
   logic        p_sel = 0, p_wr = 0, p_rd = 0, p_drv = 0, p_oe_n = 1;
   logic        p_we_n = 1, p_cs1_n = 1, p_cs2 = 0;
   logic [16:0] p_addr = '0, w_addr = '0;
   logic [7:0]  p_dout = '0, w_dat = '0;
   int          acc = 0, wcnt = 0, dcnt = 0;

   assign mem_din = din_drv;

   always @(negedge clk) begin
      logic sel, wr, rd;
      logic [1:0] code, exp_s;
      string tag;
      if (rst_n) begin
         sel = !mem_cs1_n && mem_cs2;
         wr  = sel && !mem_we_n;
         rd  = sel && mem_we_n && !mem_oe_n;
         if (rd && mem_dout_oe) chk("R7", "bus contention", 1, 0);
         if (mem_dout_oe && !p_drv && !p_oe_n) chk("R7", "driver on without OE high cycle", 0, 1);
         if (rd) acc = (p_rd && mem_addr == p_addr) ? acc + 1 : 1;
         else    acc = 0;
         if (rd && acc >= RD_NEED)
            din_drv = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : init_val(mem_addr);
         else
            din_drv = 8'hxx;
         if (wr) begin
            if (p_wr && mem_addr != p_addr) chk("R6", "address moved in strobe", 32'(mem_addr), 32'(p_addr));
            wcnt++;
            if (mem_dout_oe && p_drv && mem_dout == p_dout) dcnt++;
            else dcnt = mem_dout_oe ? 1 : 0;
            w_addr = mem_addr;
            w_dat  = mem_dout;
         end else if (p_wr) begin
            code = 2'b11;
            if (!p_we_n && mem_we_n) code = 2'b00;
            else if (!p_cs1_n && mem_cs1_n) code = 2'b01;
            else if (p_cs2 && !mem_cs2) code = 2'b10;
            exp_s = (style_q.size() != 0) ? style_q.pop_front() : 2'b11;
            tag = (exp_s == 2'b01) ? "R4" : (exp_s == 2'b10) ? "R5" : "R3";
            chk(tag, "pin ending the write", 32'(code), 32'(exp_s));
            chk("R10", "strobe cycles at least", 32'(wcnt >= WP_NEED), 1);
            chk("R10", "data setup cycles at least", 32'(dcnt >= DW_NEED), 1);
            chk("R6", "data held after strobe", {mem_dout_oe, mem_dout}, {1'b1, w_dat});
            dev_mem[int'(w_addr)] = w_dat;
            wcnt = 0;
            dcnt = 0;
         end
         p_sel = sel; p_wr = wr; p_rd = rd; p_drv = mem_dout_oe; p_oe_n = mem_oe_n;
         p_we_n = mem_we_n; p_cs1_n = mem_cs1_n; p_cs2 = mem_cs2;
         p_addr = mem_addr; p_dout = mem_dout;
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [7:0] data;
      int         due;
   } rd_exp_t;
   rd_exp_t    rd_q [$];
   logic [7:0] shadow [int];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      rd_exp_t e;
      if (rst_n && rd_valid) begin
         if (rd_q.size() == 0) begin
            chk("R2", "unexpected rd_valid", 1, 0);
         end else begin
            e = rd_q.pop_front();
            chk("R2", "read data", 32'(rd_data), 32'(e.data));
            chk("R2", "rd_valid cycle", 32'(cyc), 32'(e.due));
         end
      end
   end

   task automatic do_read(input logic [16:0] a);
      rd_exp_t e;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
      e.due  = cyc + 1 + RD_NEED;
      rd_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_write(input logic [16:0] a, input logic [7:0] d,
                           input logic [1:0] mode, input bit flip);
      int acc_cyc;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_mode = mode;
      acc_cyc = cyc + 1;
      style_q.push_back((mode == 2'b11) ? 2'b00 : mode);
      shadow[int'(a)] = d;
      @(negedge clk);
      req_valid = 1'b0;
      // R9: mode moves after acceptance, the write must keep its style
      if (flip) req_mode = mode ^ 2'b11;
      while (!req_ready) @(negedge clk);
      chk("R8", "write busy cycles", 32'(cyc - acc_cyc), 32'(WR_BUSY));
      chk("R6", "pins and drivers released",
          {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dout_oe}, 5'b10110);
   endtask

   always @(posedge clk) begin
      if (cyc > 20000 && !done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below %0d", cyc, 20000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "ready in reset", 32'(req_ready), 0);
      chk("R1", "pins in reset", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dout_oe}, 5'b10110);
      rst_n = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (!req_ready && n < RD_NEED)
            chk("R1", "pins idle while waking",
                {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dout_oe}, 5'b10110);
      end while (!req_ready && n < 40);
      chk("R1", "edges until ready", 32'(n), 32'(RD_NEED));

      // R2: reads of untouched locations, both address extremes
      do_read(17'h00000);
      do_read(17'h1FFFF);
      // R3 / R4 / R5: each write style, then read back
      do_write(17'h00010, 8'h3C, 2'b00, 0);
      do_read(17'h00010);
      do_write(17'h1FFFF, 8'hC3, 2'b01, 0);
      do_read(17'h1FFFF);
      do_write(17'h0ABCD, 8'h5A, 2'b10, 0);
      do_read(17'h0ABCD);
      // R7: write right after a read
      do_read(17'h00010);
      do_write(17'h00011, 8'h81, 2'b00, 0);
      do_read(17'h00011);
      do_write(17'h00012, 8'h7E, 2'b10, 0);
      // R9: mode changes during the write
      do_write(17'h00020, 8'hA1, 2'b01, 1);
      do_write(17'h00021, 8'hB2, 2'b10, 1);
      do_write(17'h00022, 8'hC3, 2'b00, 1);
      // R3: reserved code behaves as write-enable style
      do_write(17'h00023, 8'hD4, 2'b11, 0);
      for (int i = 0; i < 4; i++) do_read(17'h00020 + 17'(i));
      // back-to-back writes over one location in every style
      for (int i = 0; i < 9; i++) begin
         do_write(17'h10000 + 17'(i % 3), 8'(8'h11 * i), 2'(i % 3), 0);
      end
      for (int i = 0; i < 3; i++) do_read(17'h10000 + 17'(i));
      do_read(17'h00012);
      repeat (12) @(negedge clk);
      chk("R2", "reads outstanding", 32'(rd_q.size()), 0);
      chk("R3", "writes outstanding", 32'(style_q.size()), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule